// File: doc/BRIEF.md
# Gated Parallel-Load Serial Shift Register

This block is a register of eight one-bit stages. It runs from a single free-running clock. Each rising edge does one of three things. It captures a full byte broadside from the parallel inputs. It moves every stage one position toward the output end and takes a new bit from the serial input. Or, when the clock-inhibit control is high, it leaves every stage untouched. The only output is the bit held in the final stage, so software-free serialisers and bit-bangers can load a byte and stream it out most-significant stage first.

The gated clock of a discrete part is modelled here as a synchronous enable, so the design has one clock domain and no derived clocks. An active-low asynchronous clear has priority over every other input. It empties the register at once and holds it empty for as long as it stays low.

The operation chosen at each edge is decoded into one of three named operations. OP_LOAD is taken when the inhibit is low and the mode select is low. OP_SHIFT is taken when the inhibit is low and the mode select is high. OP_HOLD is taken whenever the inhibit is high. The register moves from any operation to any other on the next edge, driven only by the inputs sampled at that edge.

Top module: `gshift_reg`

## Requirements
- R1: With `inhibit`=0 and `shift_nload`=1, each rising edge moves stage k-1 into stage k for k=1..7 and copies `ser_in` into stage 0.
- R2: With `inhibit`=0 and `shift_nload`=0, stage k takes `par_in[k]` on the rising edge. Nothing changes between edges, so the load is synchronous and not immediate.
- R3: During a parallel load, `ser_in` has no effect on any stage.
- R4: With `inhibit`=1 at a rising edge, every stage keeps its value in both modes. The inhibit is sampled only at rising edges.
- R5: While `clr_n`=0, all stages are 0 at once, without waiting for an edge. Clock edges, `inhibit` and `shift_nload` have no effect while it is low.
- R6: `ser_out` is stage 7. It shows `par_in[7]` right after a load, and after seven further shifts it shows `par_in[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, rising edge active |
| clr_n | input | 1 | Asynchronous clear, active low, highest priority |
| shift_nload | input | 1 | 1 selects shifting, 0 selects parallel load |
| inhibit | input | 1 | 1 freezes the register at the next edge |
| ser_in | input | 1 | Serial bit entering stage 0 |
| par_in | input | 8 | Broadside data; bit k goes to stage k |
| ser_out | output | 1 | Content of the last stage (stage 7) |

## Verification
The clocked properties assume two things about the inputs. First, the mode select, inhibit, serial and parallel inputs are settled around every rising edge. Second, the clear is raised or lowered away from an edge, so each edge sees one well-defined operation. The stimulus keeps to this by driving all data and control inputs on falling edges. It moves `clr_n` a quarter period after a rising edge or on a falling edge, so a clear that lands in the middle of a shift sequence still never coincides with an active edge.

// File: rtl/gshift_pkg.sv
package gshift_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } op_e;

endpackage

// File: rtl/gshift_opdec.sv
module gshift_opdec
    import gshift_pkg::*;
(
    input  logic inhibit,
    input  logic shift_nload,
    output op_e  op
);

    // Inhibit wins over the mode select; the mode picks load or shift.
    always_comb begin
        if (inhibit) begin
            op = OP_HOLD;
        end else if (shift_nload) begin
            op = OP_SHIFT;
        end else begin
            op = OP_LOAD;
        end
    end

endmodule

// File: rtl/gshift_stage.sv
module gshift_stage
    import gshift_pkg::*;
(
    input  logic clk,
    input  logic clr_n,
    input  op_e  op,
    input  logic shift_d,
    input  logic load_d,
    output logic q
);

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            q <= 1'b0;
        end else begin
            unique case (op)
                OP_SHIFT: q <= shift_d;
                OP_LOAD:  q <= load_d;
                default:  q <= q;
            endcase
        end
    end

endmodule

// File: rtl/gshift_reg.sv
module gshift_reg
    import gshift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             shift_nload,
    input  logic             inhibit,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic             ser_out
);

    localparam int LAST = WIDTH - 1;

    op_e              op;
    logic [WIDTH-1:0] stage_q;
    logic [WIDTH-1:0] shift_src;

    gshift_opdec u_opdec (
        .inhibit     (inhibit),
        .shift_nload (shift_nload),
        .op          (op)
    );

    for (genvar k = 0; k < WIDTH; k++) begin : g_stage
        if (k == 0) begin : g_head
            assign shift_src[k] = ser_in;
        end else begin : g_body
            assign shift_src[k] = stage_q[k-1];
        end

        gshift_stage u_stage (
            .clk     (clk),
            .clr_n   (clr_n),
            .op      (op),
            .shift_d (shift_src[k]),
            .load_d  (par_in[k]),
            .q       (stage_q[k])
        );
    end

    always_comb begin
        ser_out = stage_q[LAST];
    end

endmodule

// File: rtl/gshift_chk.sv
module gshift_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             clr_n,
    input logic             shift_nload,
    input logic             inhibit,
    input logic             ser_in,
    input logic [WIDTH-1:0] par_in,
    input logic [WIDTH-1:0] q
);

    assert_shift_R1: assert property (@(posedge clk) disable iff (!clr_n)
        (!inhibit && shift_nload) |=> (q == {$past(q[WIDTH-2:0]), $past(ser_in)}));

    // R3: the loaded value depends only on par_in, never on ser_in
    assert_load_R2: assert property (@(posedge clk) disable iff (!clr_n)
        (!inhibit && !shift_nload) |=> (q == $past(par_in)));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!clr_n)
        inhibit |=> $stable(q));

    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!clr_n)
        $rose(clr_n) |-> (q == '0));

endmodule

bind gshift_reg gshift_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .clr_n       (clr_n),
    .shift_nload (shift_nload),
    .inhibit     (inhibit),
    .ser_in      (ser_in),
    .par_in      (par_in),
    .q           (stage_q)
);

// File: tb/gshift_reg_tb.sv
module gshift_reg_tb;

    localparam int  W      = 8;
    localparam time PERIOD = 10;

    logic         clk         = 1'b0;
    logic         clr_n       = 1'b0;
    logic         shift_nload = 1'b1;
    logic         inhibit     = 1'b0;
    logic         ser_in      = 1'b0;
    logic [W-1:0] par_in      = '0;
    logic         ser_out;

    int checks = 0;
    int errors = 0;
    bit model[$];

    always #(PERIOD/2) clk = ~clk;

    gshift_reg #(.WIDTH(W)) u_dut (
        .clk         (clk),
        .clr_n       (clr_n),
        .shift_nload (shift_nload),
        .inhibit     (inhibit),
        .ser_in      (ser_in),
        .par_in      (par_in),
        .ser_out     (ser_out)
    );

    task automatic check(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: ser_out=%0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_clear();
        model.delete();
        for (int i = 0; i < W; i++) model.push_back(1'b0);
    endtask

    // One clock: drive on the falling edge, check nothing moved before the
    // rising edge, update the reference at the edge, check a quarter later.
    task automatic step(input string tag, input logic m, input logic inh,
                        input logic s, input logic [W-1:0] p);
        @(negedge clk);
        shift_nload = m;
        inhibit     = inh;
        ser_in      = s;
        par_in      = p;
        #1;
        check({tag, " before edge"}, ser_out, model[W-1]);
        @(posedge clk);
        if (clr_n && !inh) begin
            if (m) begin
                model.push_front(s);
                void'(model.pop_back());
            end else begin
                for (int i = 0; i < W; i++) model[i] = p[i];
            end
        end
        #(PERIOD/4);
        check(tag, ser_out, model[W-1]);
    endtask

    initial begin
        #(PERIOD * 50000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int lfsr;
        model_clear();
        #(PERIOD*2 + 2);
        check("R5 reset state", ser_out, 1'b0);
        @(negedge clk);
        clr_n = 1'b1;

        // R2/R6: load, output shows par_in[7], then seven shifts bring par_in[0]
        step("R2 load A5", 1'b0, 1'b0, 1'b1, 8'hA5);
        check("R6 after load", ser_out, 1'b1);
        for (int i = 0; i < 7; i++) step("R6 shift out", 1'b1, 1'b0, 1'b0, 8'h00);
        check("R6 par_in[0] after 7 shifts", ser_out, 1'b1);
        step("R1 shift zero in", 1'b1, 1'b0, 1'b0, 8'hFF);

        // R1: serial fill with a pattern, then flush it out
        for (int i = 0; i < 8; i++) step("R1 serial fill", 1'b1, 1'b0, ((8'b0100_1011 >> i) & 1) != 0, 8'h5A);
        for (int i = 0; i < 8; i++) step("R1 serial flush", 1'b1, 1'b0, 1'b0, 8'hFF);

        // R3: load zeros with ser_in high, shift out: only zeros may appear
        step("R3 load with ser_in=1", 1'b0, 1'b0, 1'b1, 8'h00);
        for (int i = 0; i < 8; i++) step("R3 ser_in ignored on load", 1'b1, 1'b0, 1'b0, 8'hFF);

        // R4: inhibit in shift mode and in load mode, then shift out
        step("R2 load 3C", 1'b0, 1'b0, 1'b0, 8'h3C);
        for (int i = 0; i < 4; i++) step("R4 inhibit shift mode", 1'b1, 1'b1, i[0], 8'h00);
        for (int i = 0; i < 3; i++) step("R4 inhibit load mode", 1'b0, 1'b1, 1'b1, 8'hFF);
        for (int i = 0; i < 8; i++) step("R4 contents kept", 1'b1, 1'b0, 1'b0, 8'h00);

        // R5: clear in the middle of a shift sequence
        step("R2 load FF", 1'b0, 1'b0, 1'b0, 8'hFF);
        for (int i = 0; i < 3; i++) step("R1 shift ones", 1'b1, 1'b0, 1'b1, 8'h00);
        clr_n = 1'b0;
        #1;
        model_clear();
        check("R5 immediate clear", ser_out, 1'b0);
        step("R5 load ignored in clear", 1'b0, 1'b0, 1'b1, 8'hFF);
        step("R5 shift ignored in clear", 1'b1, 1'b0, 1'b1, 8'hFF);
        step("R5 inhibit ignored in clear", 1'b1, 1'b1, 1'b1, 8'hFF);
        @(negedge clk);
        clr_n = 1'b1;
        for (int i = 0; i < 8; i++) step("R5 all stages zero", 1'b1, 1'b0, 1'b0, 8'hFF);

        // Mixed stimulus against the reference model
        lfsr = 32'h1D2C_3B4A;
        for (int i = 0; i < 60; i++) begin
            logic m, inh, s;
            lfsr = (lfsr << 1) ^ ((lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]) ? 1 : 0);
            inh = (lfsr[3:0] == 4'h0);
            m   = (lfsr[6:4] != 3'd0);
            s   = lfsr[9];
            step(inh ? "R4 mixed" : (m ? "R1 mixed" : "R2 mixed"), m, inh, s, lfsr[19:12]);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule